// File: doc/BRIEF.md
# I2C Register-Write Master

This block is a single-master two-wire serial bus controller that carries out one register write per request. A one-cycle `start_i` pulse captures a 7-bit device address, an 8-bit register pointer and an 8-bit data value. The block then drives the bus through a start condition and three bytes: the device address with a write direction bit of 0, the register pointer, and the data. It checks the acknowledge after each byte and closes with a stop condition.

SCL is driven only by this block. SDA is modelled as open drain. `sda_oe_o` high pulls the line low. `sda_oe_o` low releases it, and a released line reads back high through its pull-up on `sda_i`.

Each SCL period is split into four equal quarters. The length of a quarter comes from the system clock frequency and the selected bus rate: standard (100 kbit/s) or fast (400 kbit/s). If any acknowledge reads as 1, the block stops sending bytes, flags `nack_o` and closes the bus with a stop condition.

Top module: `i2c_regwr_master`

## Requirements
- R1: After reset, and whenever the block is idle, `scl_o` is 1 and `sda_oe_o` is 0. After reset, `busy_o`, `done_o` and `nack_o` are 0.
- R2: A transfer opens with two quarters in which SCL is high. In the first quarter SDA is released. In the second quarter SDA is pulled low, which is the start condition.
- R3: Each byte takes nine SCL clocks, and each clock takes four quarters in the order low, low, high, high. In the first low quarter SDA keeps its previous level, and in the second low quarter SDA takes the new bit. The bytes go out in this order: `{dev_addr_i, 1'b0}`, then `reg_addr_i`, then `wr_data_i`. Bits are sent most significant first, and a 1 bit means SDA is released.
- R4: While SCL stays high inside a byte, SDA does not change.
- R5: During the ninth clock of each byte, SDA is released. `sda_i` is sampled at the end of the first high quarter of that clock. A sample of 0 counts as acknowledged.
- R6: If an acknowledge samples as 1, no further byte is sent, the stop sequence follows at once, and `nack_o` goes to 1.
- R7: The stop sequence takes four quarters. The lines go through (SCL low, SDA held), (low, pulled low), (high, pulled low), (high, released). Releasing SDA while SCL is high is the stop condition.
- R8: A quarter lasts `CLK_HZ/(4*100000)` system clocks when `fast_i` was 0 at the accepted start, and `CLK_HZ/(4*400000)` system clocks when it was 1.
- R9: `busy_o` is 1 from the cycle after an accepted start through the last stop quarter. `done_o` is 1 for exactly the single cycle after that, with `busy_o` 0. `nack_o` clears when the next start is accepted and otherwise holds its value.
- R10: While busy, `start_i` has no effect and changes on `fast_i` and the data inputs have no effect. The running transfer continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, accepted only when idle |
| fast_i | input | 1 | 1 selects the 400 kbit/s rate, captured at start |
| dev_addr_i | input | 7 | Target device address |
| reg_addr_i | input | 8 | Register pointer sent as the second byte |
| wr_data_i | input | 8 | Data sent as the third byte |
| sda_i | input | 1 | Level read back from the SDA line |
| scl_o | output | 1 | SCL level |
| sda_oe_o | output | 1 | 1 pulls SDA low, 0 releases it |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle pulse when the bus is back to idle |
| nack_o | output | 1 | Last transfer ended on a missing acknowledge |

## Verification
All outputs are registered.

Every result except `done_o` appears one system clock after the edge that causes it. `busy_o` rises one clock after `start_i` is accepted, and each quarter boundary moves SCL or SDA exactly `Q` clocks after the previous boundary. `done_o` appears one clock after the last stop quarter ends.

An acknowledge sampled at the end of a high quarter decides the next quarter's lines, one quarter later. The bench builds, from the requirements alone, a queue holding one expected output tuple per system clock. It drives the slave's acknowledge from the same queue and compares that tuple against the outputs at the falling clock edge of every cycle.

// File: rtl/i2c_regwr_master.sv
module i2c_regwr_master #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int STD_HZ  = 100_000,
  parameter int FAST_HZ = 400_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       fast_i,
  input  logic [6:0] dev_addr_i,
  input  logic [7:0] reg_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic       sda_i,
  output logic       scl_o,
  output logic       sda_oe_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       nack_o
);
  localparam int QS = CLK_HZ / (4 * STD_HZ);
  localparam int QF = CLK_HZ / (4 * FAST_HZ);
  localparam int CW = $clog2(QS + 1);
  localparam logic [1:0] ST_IDLE = 2'd0, ST_START = 2'd1, ST_BIT = 2'd2, ST_STOP = 2'd3;

  logic [1:0]    st, qtr, byten;
  logic [3:0]    bitn;
  logic [23:0]   frame;
  logic [CW-1:0] cnt;
  logic          fast_q, ack_q;

  wire [CW-1:0] qlim = fast_q ? CW'(QF - 1) : CW'(QS - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; qtr <= '0; byten <= '0; bitn <= '0; frame <= '0; cnt <= '0;
      fast_q <= 1'b0; ack_q <= 1'b0;
      scl_o <= 1'b1; sda_oe_o <= 1'b0; busy_o <= 1'b0; done_o <= 1'b0; nack_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (st == ST_IDLE) begin
        if (start_i) begin
          frame  <= {dev_addr_i, 1'b0, reg_addr_i, wr_data_i};
          fast_q <= fast_i;
          st     <= ST_START;
          qtr    <= '0;
          cnt    <= '0;
          busy_o <= 1'b1;
          nack_o <= 1'b0;
        end
      end else if (cnt != qlim) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        qtr <= qtr + 1'b1;
        case (st)
          ST_START:
            if (qtr == 2'd0) sda_oe_o <= 1'b1;
            else begin
              st <= ST_BIT; qtr <= '0; scl_o <= 1'b0; bitn <= '0; byten <= '0;
            end
          ST_BIT:
            case (qtr)
              2'd0: sda_oe_o <= (bitn == 4'd8) ? 1'b0 : ~frame[23];
              2'd1: scl_o <= 1'b1;
              2'd2: if (bitn == 4'd8) ack_q <= sda_i;
              default: begin
                scl_o <= 1'b0;
                if (bitn != 4'd8) begin
                  frame <= frame << 1;
                  bitn  <= bitn + 1'b1;
                end else if (ack_q || byten == 2'd2) begin
                  st     <= ST_STOP;
                  nack_o <= ack_q;
                end else begin
                  bitn  <= '0;
                  byten <= byten + 1'b1;
                end
              end
            endcase
          default:
            case (qtr)
              2'd0: sda_oe_o <= 1'b1;
              2'd1: scl_o <= 1'b1;
              2'd2: sda_oe_o <= 1'b0;
              default: begin
                st <= ST_IDLE; busy_o <= 1'b0; done_o <= 1'b1;
              end
            endcase
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regwr_master_chk.sv
module i2c_regwr_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       scl_o,
  input logic       sda_oe_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       nack_o,
  input logic [1:0] st
);
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (scl_o && !sda_oe_o));
  a_r2_start_only_in_start: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && $rose(sda_oe_o)) |-> st == 2'd1);
  a_r4_sda_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && $past(st) == 2'd2 && scl_o && $past(scl_o)) |-> $stable(sda_oe_o));
  a_r7_stop_only_in_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_o && $past(scl_o) && $fell(sda_oe_o)) |-> st == 2'd3);
  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);
  a_r9_nack_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !start_i) |=> $stable(nack_o));
endmodule

bind i2c_regwr_master i2c_regwr_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .scl_o(scl_o), .sda_oe_o(sda_oe_o),
  .busy_o(busy_o), .done_o(done_o), .nack_o(nack_o), .st(st)
);

// File: tb/i2c_regwr_master_test.sv
module i2c_regwr_master_test;
  localparam int CLK_PERIOD = 10;
  localparam int CLK_HZ = 8_000_000;
  localparam int QS = CLK_HZ / (4 * 100_000);
  localparam int QF = CLK_HZ / (4 * 400_000);

  typedef struct packed {
    logic scl, oe, busy, done, nack, pull;
    logic [3:0] tag;
  } ent_t;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, fast_i = 1'b0, pull = 1'b0;
  logic [6:0] dev_addr_i = '0;
  logic [7:0] reg_addr_i = '0, wr_data_i = '0;
  logic scl_o, sda_oe_o, busy_o, done_o, nack_o;
  wire  sda_i = ~(sda_oe_o | pull);

  int checks = 0, errors = 0;
  ent_t mq[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  i2c_regwr_master #(.CLK_HZ(CLK_HZ)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .fast_i(fast_i),
    .dev_addr_i(dev_addr_i), .reg_addr_i(reg_addr_i), .wr_data_i(wr_data_i),
    .sda_i(sda_i), .scl_o(scl_o), .sda_oe_o(sda_oe_o), .busy_o(busy_o),
    .done_o(done_o), .nack_o(nack_o)
  );

  function automatic string tagname(input logic [3:0] t);
    case (t)
      4'd2: return "R2 start";
      4'd3: return "R3 data bit";
      4'd5: return "R5 acknowledge";
      4'd7: return "R7 stop";
      default: return "R9 completion";
    endcase
  endfunction

  task automatic push(input logic s, input logic o, input logic b, input logic d,
                      input logic n, input logic p, input logic [3:0] t, input int len);
    ent_t e;
    e = '{scl: s, oe: o, busy: b, done: d, nack: n, pull: p, tag: t};
    repeat (len) mq.push_back(e);
  endtask

  // Expected waveform, built from R2, R3, R5, R6, R7, R8 and R9.
  task automatic build(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d,
                       input logic fast, input logic [2:0] ackm);
    logic [7:0] by [3];
    int q;
    logic prev, v, nk, pl;
    by[0] = {a, 1'b0}; by[1] = r; by[2] = d;
    q = fast ? QF : QS;
    nk = 1'b0;
    push(1, 0, 1, 0, 0, 0, 2, q);
    push(1, 1, 1, 0, 0, 0, 2, q);
    prev = 1'b1;
    for (int b = 0; b < 3 && !nk; b++) begin
      for (int k = 0; k < 9; k++) begin
        v  = (k < 8) ? ~by[b][7-k] : 1'b0;
        pl = (k == 8) && ackm[b];
        push(0, prev, 1, 0, 0, pl, (k < 8) ? 4'd3 : 4'd5, q);
        push(0, v,    1, 0, 0, pl, (k < 8) ? 4'd3 : 4'd5, q);
        push(1, v,    1, 0, 0, pl, (k < 8) ? 4'd3 : 4'd5, q);
        push(1, v,    1, 0, 0, pl, (k < 8) ? 4'd3 : 4'd5, q);
        prev = v;
      end
      if (!ackm[b]) nk = 1'b1;  // R6: abort after the refused byte
    end
    push(0, prev, 1, 0, nk, 0, 7, q);
    push(0, 1,    1, 0, nk, 0, 7, q);
    push(1, 1,    1, 0, nk, 0, 7, q);
    push(1, 0,    1, 0, nk, 0, 7, q);
    push(1, 0,    0, 1, nk, 0, 9, 1);
    push(1, 0,    0, 0, nk, 0, 9, 1);
  endtask

  task automatic run(input logic [6:0] a, input logic [7:0] r, input logic [7:0] d,
                     input logic fast, input logic [2:0] ackm, input logic disturb);
    ent_t e;
    int idx;
    logic [4:0] got, exp;
    build(a, r, d, fast, ackm);
    @(negedge clk);
    dev_addr_i = a; reg_addr_i = r; wr_data_i = d; fast_i = fast; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    idx = 0;
    while (mq.size() > 0) begin
      e = mq.pop_front();
      pull = e.pull;
      got = {scl_o, sda_oe_o, busy_o, done_o, nack_o};
      exp = {e.scl, e.oe, e.busy, e.done, e.nack};
      checks++;
      if (got !== exp) begin
        errors++;
        $display("FAIL %s cycle %0d: {scl,oe,busy,done,nack} got %b expected %b",
                 tagname(e.tag), idx, got, exp);
      end
      if (disturb && idx == 40) begin  // R10: request and rate change while busy
        start_i = 1'b1; fast_i = ~fast; dev_addr_i = ~a; wr_data_i = ~d;
      end
      if (disturb && idx == 41) start_i = 1'b0;
      idx++;
      @(negedge clk);
    end
    pull = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if ({scl_o, sda_oe_o, busy_o, done_o, nack_o} !== 5'b10000) begin
      errors++;
      $display("FAIL R1 reset state: got %b expected 10000",
               {scl_o, sda_oe_o, busy_o, done_o, nack_o});
    end
    run(7'h69, 8'h25, 8'h19, 1'b0, 3'b111, 1'b0);   // R3 R8 standard rate
    run(7'h7F, 8'h00, 8'hFF, 1'b1, 3'b111, 1'b0);   // R3 R8 fast rate
    run(7'h2A, 8'hC3, 8'h5A, 1'b0, 3'b000, 1'b0);   // R6 address refused
    repeat (5) @(negedge clk);
    checks++;
    if (nack_o !== 1'b1 || busy_o !== 1'b0) begin
      errors++;
      $display("FAIL R9 nack hold: got nack=%b busy=%b expected nack=1 busy=0", nack_o, busy_o);
    end
    run(7'h11, 8'hF0, 8'h3C, 1'b1, 3'b001, 1'b0);   // R6 register byte refused, R9 nack cleared
    run(7'h55, 8'h81, 8'h7E, 1'b0, 3'b011, 1'b0);   // R6 data byte refused
    run(7'h0C, 8'h99, 8'h66, 1'b1, 3'b111, 1'b1);   // R10 inputs ignored while busy
    run(7'h2B, 8'hAA, 8'h0F, 1'b0, 3'b111, 1'b0);   // R4 R5 alternating bits
    repeat (3) @(negedge clk);
    checks++;
    if ({scl_o, sda_oe_o, busy_o, done_o, nack_o} !== 5'b10000) begin
      errors++;
      $display("FAIL R1 idle after transfer: got %b expected 10000",
               {scl_o, sda_oe_o, busy_o, done_o, nack_o});
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule